// File: doc/BRIEF.md
# Morse Distress Beacon Sequencer (Microcoded, Unfactored)

This block drives a single lamp with the Morse distress call: three dots, three dashes and three dots, then repeats. It runs for as long as an enable input is held high. It is a microcoded state machine. A constant lookup table is indexed by the current step number joined with the enable bit. Each table word supplies the next step number and the lamp value that goes with it. A step register and a lamp register capture that word on every clock edge.

The machine is completely unfactored. Every clock period of the 37-clock repeat has its own step code, and no separate counter or timer exists. The timing lives entirely in the table contents. The table is computed at elaboration from the dot, dash and gap lengths kept in the package. One further code, the all-ones value, is the idle step.

Dropping the enable returns the machine to idle on the next edge, from any step. A synchronous reset does the same.

Top module: `sos_flasher`

## Requirements
- R1: While `rst` is high at a rising edge, the lamp output is 0 after that edge. With `flash` high when `rst` is released, the next edge starts the pattern at its first lit clock.
- R2: While `flash` is low, `light` stays 0 on every clock.
- R3: From idle, the first rising edge that samples `flash` high makes `light` 1 directly after that edge (one clock of latency).
- R4: Each dot letter is three 1-clock lit periods, each separated from the next by exactly 1 dark clock.
- R5: The dash letter is three 4-clock lit periods, each separated from the next by exactly 1 dark clock.
- R6: Between letters within one call, the lamp is dark for exactly 3 clocks.
- R7: After the last dot of a call, the lamp is dark for exactly 7 clocks, and the pattern then repeats with a period of 37 clocks for as long as `flash` stays high.
- R8: If `flash` is low at an edge, from any step (including in the middle of a dash), the lamp is 0 after that edge. Raising `flash` again restarts the pattern from its first dot.
- R9: The table address is the step code with `flash` as its least significant bit. Every word whose `flash` bit is 0 holds the idle step and a dark lamp. The step code is never outside 0..36 or idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to idle |
| flash | input | 1 | Enable: high runs the distress pattern, low returns to idle |
| light | output | 1 | Registered lamp drive |

## Verification
The assertions check the step sequencing on every cycle:
- a low `flash` or a reset lands in idle with a dark lamp;
- idle with `flash` high goes to step 0 with the lamp lit;
- each active step advances by one, and the last step wraps to 0;
- the step code never takes an unused value.

The exact lamp waveform cannot be checked by those properties. That covers the dot and dash lengths, the 1-, 3- and 7-clock dark gaps, the 37-clock period and the restart after an abort in mid-dash. Only the bench's scenarios show these, by comparing every clock against a pattern assembled independently from the requirements.

// File: rtl/sos_pkg.sv
package sos_pkg;

    // Timing of the call, in clocks
    localparam int DOT_LEN    = 1;
    localparam int DASH_LEN   = 4;
    localparam int SYM_GAP    = 1;
    localparam int LETTER_GAP = 3;
    localparam int CALL_GAP   = 7;
    localparam int SYMS       = 3;   // symbols per letter
    localparam int LETTERS    = 3;   // letters per call

    localparam int CYCLE_LEN = (LETTERS - 1) * SYMS * DOT_LEN + SYMS * DASH_LEN
                             + LETTERS * (SYMS - 1) * SYM_GAP
                             + (LETTERS - 1) * LETTER_GAP + CALL_GAP;
    localparam int LAST_STEP = CYCLE_LEN - 1;
    localparam int STATE_W   = $clog2(CYCLE_LEN + 1);
    localparam int ADDR_W    = STATE_W + 1;
    localparam int ROM_DEPTH = 1 << ADDR_W;
    localparam int IDLE_STEP = (1 << STATE_W) - 1;

    typedef logic [STATE_W-1:0] step_t;
    typedef logic [ADDR_W-1:0]  uaddr_t;

    typedef struct packed {
        step_t next_step;
        logic  lamp;
    } uword_t;

    localparam step_t IDLE = step_t'(IDLE_STEP);
    localparam step_t LAST = step_t'(LAST_STEP);

    // Lamp value for a step of the call; the middle letter uses dashes
    function automatic logic lamp_at(input int step);
        int   pos;
        int   len;
        logic lit;
        pos = 0;
        lit = 1'b0;
        for (int l = 0; l < LETTERS; l++) begin
            for (int s = 0; s < SYMS; s++) begin
                len = (l == LETTERS / 2) ? DASH_LEN : DOT_LEN;
                if (step >= pos && step < pos + len) lit = 1'b1;
                pos = pos + len;
                if (s < SYMS - 1) pos = pos + SYM_GAP;
            end
            if (l < LETTERS - 1) pos = pos + LETTER_GAP;
        end
        return lit;
    endfunction

    // Microcode word for one table address {step, flash}
    function automatic uword_t build_word(input int addr);
        int     step;
        int     nxt;
        uword_t w;
        step = addr >> 1;
        if ((addr & 1) == 0)         nxt = IDLE_STEP;
        else if (step == IDLE_STEP)  nxt = 0;
        else if (step < LAST_STEP)   nxt = step + 1;
        else if (step == LAST_STEP)  nxt = 0;
        else                         nxt = IDLE_STEP;
        w.next_step = step_t'(nxt);
        w.lamp      = (nxt == IDLE_STEP) ? 1'b0 : lamp_at(nxt);
        return w;
    endfunction

endpackage

// File: rtl/sos_ucode_rom.sv
module sos_ucode_rom
    import sos_pkg::*;
(
    input  uaddr_t addr,
    output uword_t word
);
    uword_t table_w [ROM_DEPTH];

    for (genvar a = 0; a < ROM_DEPTH; a++) begin : g_word
        assign table_w[a] = build_word(a);
    end

    assign word = table_w[addr];
endmodule

// File: rtl/sos_ctrl_regs.sv
module sos_ctrl_regs
    import sos_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  uword_t d,
    output step_t  step_q,
    output logic   lamp_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= IDLE;
            lamp_q <= 1'b0;
        end else begin
            step_q <= d.next_step;
            lamp_q <= d.lamp;
        end
    end
endmodule

// File: rtl/sos_flasher.sv
module sos_flasher
    import sos_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flash,
    output logic light
);
    step_t  step_q;
    logic   lamp_q;
    uaddr_t uaddr;
    uword_t uword;

    assign uaddr = {step_q, flash};

    sos_ucode_rom u_rom (
        .addr (uaddr),
        .word (uword)
    );

    sos_ctrl_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .d      (uword),
        .step_q (step_q),
        .lamp_q (lamp_q)
    );

    assign light = lamp_q;

    // R1: reset lands in idle, dark
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (step_q == IDLE && !light));

    // R8: low enable returns to idle from any step
    a_r8_abort_idle: assert property (@(posedge clk) disable iff (rst)
        !flash |=> (step_q == IDLE && !light));

    // R3: idle with enable high starts at step 0, lit
    a_r3_start_lit: assert property (@(posedge clk) disable iff (rst)
        (flash && step_q == IDLE) |=> (step_q == '0 && light));

    // R7: active steps advance by one
    a_r7_advance: assert property (@(posedge clk) disable iff (rst)
        (flash && step_q != IDLE && step_q < LAST)
            |=> (step_q == $past(step_q) + step_t'(1)));

    // R7: last step wraps to the first
    a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
        (flash && step_q == LAST) |=> (step_q == '0 && light));

    // R9: step code stays legal
    a_r9_legal_step: assert property (@(posedge clk) disable iff (rst)
        (step_q <= LAST || step_q == IDLE));
endmodule

// File: tb/sos_flasher_tb.sv
`timescale 1ns/1ps
module sos_flasher_tb_top;
    localparam int PERIOD = 37;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flash = 1'b0;
    logic light;

    int errors = 0;
    int checks = 0;

    logic  exp_pat [PERIOD];
    string exp_tag [PERIOD];
    int    fill = 0;

    always #10 clk = ~clk;

    sos_flasher dut_i (
        .clk   (clk),
        .rst   (rst),
        .flash (flash),
        .light (light)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: light actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic add_run(input int n, input logic v, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_pat[fill] = v;
            exp_tag[fill] = tag;
            fill++;
        end
    endtask

    task automatic build_expect();
        add_run(1, 1, "R4"); add_run(1, 0, "R4"); add_run(1, 1, "R4");
        add_run(1, 0, "R4"); add_run(1, 1, "R4");
        add_run(3, 0, "R6");
        add_run(4, 1, "R5"); add_run(1, 0, "R5"); add_run(4, 1, "R5");
        add_run(1, 0, "R5"); add_run(4, 1, "R5");
        add_run(3, 0, "R6");
        add_run(1, 1, "R4"); add_run(1, 0, "R4"); add_run(1, 1, "R4");
        add_run(1, 0, "R4"); add_run(1, 1, "R4");
        add_run(7, 0, "R7");
        exp_tag[0] = "R3";
    endtask

    // flash must already be high; checks n clocks of the pattern from step 0
    task automatic run_pattern(input int n, input string ctx);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); @(negedge clk);
            check($sformatf("%s/%s step %0d", exp_tag[k % PERIOD], ctx, k % PERIOD),
                  light, exp_pat[k % PERIOD]);
        end
    endtask

    task automatic t_reset_and_idle();
        rst = 1'b1; flash = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset dark", light, 1'b0);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); @(negedge clk);
            check("R2 idle dark", light, 1'b0);
        end
    endtask

    task automatic t_continuous();
        flash = 1'b1;
        run_pattern(2 * PERIOD + 3, "R7 repeat");
        flash = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R8 drop after run", light, 1'b0);
    endtask

    task automatic t_abort_mid_dash();
        flash = 1'b1;
        run_pattern(10, "R8 pre");
        flash = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); @(negedge clk);
            check("R8 abort dark", light, 1'b0);
        end
        flash = 1'b1;
        run_pattern(PERIOD, "R8 restart");
        flash = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_one_clock_pulse();
        flash = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R3 first lit", light, 1'b1);
        flash = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R8 short enable dark", light, 1'b0);
    endtask

    task automatic t_reset_mid_run();
        flash = 1'b1;
        run_pattern(15, "R1 pre");
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 reset mid run", light, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R1 reset held", light, 1'b0);
        rst = 1'b0;
        run_pattern(12, "R1 resume");
        flash = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R9 flash low word dark", light, 1'b0);
    endtask

    initial begin
        build_expect();
        t_reset_and_idle();
        t_continuous();
        t_abort_mid_dash();
        t_one_clock_pulse();
        t_reset_mid_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule